// File: doc/BRIEF.md
# Four-Wide Register Rename Stage

This block translates the architectural register numbers of up to four decoded instructions per clock into physical register tags. Each instruction lane may name two source registers and two destination registers. A load that also updates its base register uses both destination slots. Sources are looked up in a speculative map table. Every destination takes a fresh tag from a circular free list. When an earlier lane in the same group writes a register that a later lane reads, the later lane gets the tag that was just handed out, not the map entry. For each destination the block also reports the tag it displaces, so a later stage can free that tag.

The rename result is presented combinationally in the same cycle as the request, gated by `in_ready`. A group that needs more tags than remain stalls as a whole. The free list takes back up to four tags per clock through a return port. A commit port keeps a committed copy of the map and a committed read pointer. A flush rolls the speculative map and the allocation pointer back to that committed state, so tags handed out after the last commit are issued again. The widths in this note are for the default parameters: 4 lanes, 32 architectural registers, 64 physical tags.

Top module: `reg_rename4`

## Requirements
- R1: After reset, architectural register i maps to physical tag i. The free list holds tags 32 to 63 in ascending order. `in_ready` is high and `out_valid` is low.
- R2: A used source with no writer in an earlier valid lane of the group gets the map-table tag for its register.
- R3: A used source whose register is written by an earlier valid lane of the group gets the newest such tag. Newer means a higher lane index, and within one lane destination slot 1 is newer than slot 0. A lane's own destinations never feed its own sources.
- R4: New tags come from the free-list head in order: lane 0 first, and within a lane slot 0 then slot 1. Only used destinations of valid lanes take a tag, and no tag appears twice in one group.
- R5: Each used destination reports the tag its register mapped to just before it: the map entry, an earlier lane's new tag, or its own lane's slot 0 tag when slot 1 names the same register.
- R6: After an accepted group, each written register maps to the tag of its newest writer in that group. This holds even when all eight slots write the same register.
- R7: When the free count is below the number of tags the group needs, `in_ready` and `out_valid` are low. No tag is consumed and no map entry changes.
- R8: Up to four returned tags per cycle are appended to the free-list tail in lane order. They become allocatable from the next cycle, after the tags already queued.
- R9: Committed entries update the committed map in lane order. Each entry advances the committed read pointer by one.
- R10: During a flush `in_ready` is low and nothing is renamed. From the next cycle the map equals the committed map, including that cycle's commits. Allocation then restarts from the committed read pointer.
- R11: A lane whose valid bit is low takes no tag, changes no map entry and has its `out_lane_v` bit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Roll back to the committed state |
| in_valid | input | 1 | A rename group is presented |
| in_lane_v | input | 4 | Per-lane valid, bit k = lane k |
| in_src_use | input | 4x2 | Source slot used, [lane][slot] |
| in_src | input | 4x2x5 | Source architectural registers |
| in_dst_use | input | 4x2 | Destination slot used, [lane][slot] |
| in_dst | input | 4x2x5 | Destination architectural registers |
| in_ready | output | 1 | Group can be renamed this cycle |
| out_valid | output | 1 | Group accepted and renamed |
| out_lane_v | output | 4 | Renamed lanes |
| out_psrc | output | 4x2x6 | Source physical tags |
| out_pdst | output | 4x2x6 | New destination tags (zero when unused) |
| out_pold | output | 4x2x6 | Tags displaced by each destination |
| fr_v | input | 4 | Returned tag valid per lane |
| fr_tag | input | 4x6 | Returned tags |
| cm_v | input | 4 | Commit entry valid per lane |
| cm_arch | input | 4x5 | Committed architectural register |
| cm_tag | input | 4x6 | Committed physical tag |

## Verification
The hardest state to reach is a flush whose rollback has to undo a long run of speculative allocations. It must also pick up commits made in the same cycle, after the free list has wrapped and been refilled through the return port. The stimulus first drains the free list with full eight-destination groups until a group stalls. It then commits the oldest allocations and returns eight tags across two cycles. After more commits, the flush arrives together with two commits. A final group reads the committed registers and draws fresh tags, so the rewound pointer and the restored map are seen at the outputs. A reference model that keeps an allocation log supplies the expected values.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int RN_LANES     = 4;
  localparam int RN_ARCH_REGS = 32;
  localparam int RN_PHYS_REGS = 64;

  // Two slots per lane: slot 0 is serviced before slot 1.
  typedef enum logic {SLOT_A = 1'b0, SLOT_B = 1'b1} rn_slot_e;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int LANES     = rn_pkg::RN_LANES,
  parameter int ARCH_REGS = rn_pkg::RN_ARCH_REGS,
  parameter int PHYS_REGS = rn_pkg::RN_PHYS_REGS,
  localparam int DEPTH    = PHYS_REGS - ARCH_REGS,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int PTR_W    = IDX_W + 1,
  localparam int TAG_W    = $clog2(PHYS_REGS),
  localparam int SLOTS    = 2 * LANES,
  localparam int CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         alloc_en,
  input  logic [CNT_W-1:0]             alloc_num,
  input  logic [CNT_W-1:0]             commit_num,
  input  logic [LANES-1:0]             free_v,
  input  logic [LANES-1:0][TAG_W-1:0]  free_tag,
  output logic [SLOTS-1:0][TAG_W-1:0]  rd_tag,
  output logic [PTR_W-1:0]             avail,
  output logic [PTR_W-1:0]             head_o
);
  logic [DEPTH-1:0][TAG_W-1:0] mem_q, mem_d;
  logic [PTR_W-1:0]            head_q, head_d;
  logic [PTR_W-1:0]            tail_q, tail_d;
  logic [PTR_W-1:0]            chead_q, chead_d;
  logic [SLOTS-1:0][PTR_W-1:0] rd_ptr;

  // Next-state: appends at the tail, head movement, committed head movement.
  always_comb begin
    logic [PTR_W-1:0] wr_ofs;
    logic [PTR_W-1:0] wr_ptr;
    mem_d  = mem_q;
    wr_ofs = '0;
    wr_ptr = '0;
    for (int l = 0; l < LANES; l++) begin
      if (free_v[l]) begin
        wr_ptr = tail_q + wr_ofs;
        mem_d[wr_ptr[IDX_W-1:0]] = free_tag[l];
        wr_ofs = wr_ofs + PTR_W'(1);
      end
    end
    tail_d  = tail_q + wr_ofs;
    chead_d = chead_q + PTR_W'(commit_num);
    if (flush)         head_d = chead_d;
    else if (alloc_en) head_d = head_q + PTR_W'(alloc_num);
    else               head_d = head_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= TAG_W'(ARCH_REGS + i);
      head_q  <= '0;
      tail_q  <= PTR_W'(DEPTH);
      chead_q <= '0;
    end else begin
      if (|free_v)            mem_q   <= mem_d;
      if (|free_v)            tail_q  <= tail_d;
      if (flush || alloc_en)  head_q  <= head_d;
      if (commit_num != '0)   chead_q <= chead_d;
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_rd
    assign rd_ptr[k] = head_q + PTR_W'(k);
    assign rd_tag[k] = mem_q[rd_ptr[k][IDX_W-1:0]];
  end

  assign avail  = tail_q - head_q;
  assign head_o = head_q;
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable #(
  parameter int LANES     = rn_pkg::RN_LANES,
  parameter int ARCH_REGS = rn_pkg::RN_ARCH_REGS,
  parameter int PHYS_REGS = rn_pkg::RN_PHYS_REGS,
  localparam int AREG_W   = $clog2(ARCH_REGS),
  localparam int PTAG_W   = $clog2(PHYS_REGS),
  localparam int SLOTS    = 2 * LANES,
  localparam int RD_N     = 2 * SLOTS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic [RD_N-1:0][AREG_W-1:0]   rd_arch,
  output logic [RD_N-1:0][PTAG_W-1:0]   rd_tag,
  input  logic [SLOTS-1:0]              wr_v,
  input  logic [SLOTS-1:0][AREG_W-1:0]  wr_arch,
  input  logic [SLOTS-1:0][PTAG_W-1:0]  wr_tag,
  input  logic [LANES-1:0]              cm_v,
  input  logic [LANES-1:0][AREG_W-1:0]  cm_arch,
  input  logic [LANES-1:0][PTAG_W-1:0]  cm_tag
);
  logic [ARCH_REGS-1:0][PTAG_W-1:0] map_q, map_d;
  logic [ARCH_REGS-1:0][PTAG_W-1:0] cmap_q, cmap_d;

  // Writes applied in program order so the newest writer wins.
  always_comb begin
    cmap_d = cmap_q;
    for (int l = 0; l < LANES; l++)
      if (cm_v[l]) cmap_d[cm_arch[l]] = cm_tag[l];
    map_d = map_q;
    for (int w = 0; w < SLOTS; w++)
      if (wr_v[w]) map_d[wr_arch[w]] = wr_tag[w];
    if (flush) map_d = cmap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) begin
        map_q[i]  <= PTAG_W'(i);
        cmap_q[i] <= PTAG_W'(i);
      end
    end else begin
      if (flush || (|wr_v)) map_q  <= map_d;
      if (|cm_v)            cmap_q <= cmap_d;
    end
  end

  for (genvar r = 0; r < RD_N; r++) begin : g_rd
    assign rd_tag[r] = map_q[rd_arch[r]];
  end
endmodule

// File: rtl/rn_bypass.sv
module rn_bypass #(
  parameter int LANES  = rn_pkg::RN_LANES,
  parameter int AREG_W = 5,
  parameter int PTAG_W = 6
) (
  input  logic [LANES-1:0]                   lane_v,
  input  logic [LANES-1:0][1:0][AREG_W-1:0]  src_arch,
  input  logic [LANES-1:0][1:0]              dst_use,
  input  logic [LANES-1:0][1:0][AREG_W-1:0]  dst_arch,
  input  logic [LANES-1:0][1:0][PTAG_W-1:0]  map_src,
  input  logic [LANES-1:0][1:0][PTAG_W-1:0]  map_old,
  input  logic [LANES-1:0][1:0][PTAG_W-1:0]  new_tag,
  output logic [LANES-1:0][1:0][PTAG_W-1:0]  psrc,
  output logic [LANES-1:0][1:0][PTAG_W-1:0]  pold
);
  // Sources: scan strictly earlier lanes, oldest first, so the newest producer wins.
  always_comb begin
    logic [PTAG_W-1:0] t;
    t = '0;
    for (int k = 0; k < LANES; k++) begin
      for (int s = 0; s < 2; s++) begin
        t = map_src[k][s];
        for (int j = 0; j < LANES; j++)
          if (j < k)
            for (int d = 0; d < 2; d++)
              if (lane_v[j] && dst_use[j][d] && dst_arch[j][d] == src_arch[k][s])
                t = new_tag[j][d];
        psrc[k][s] = t;
      end
    end
  end

  // Displaced tags: earlier lanes, then slot 0 of the same lane for slot 1.
  always_comb begin
    logic [PTAG_W-1:0] o;
    o = '0;
    for (int k = 0; k < LANES; k++) begin
      for (int s = 0; s < 2; s++) begin
        o = map_old[k][s];
        for (int j = 0; j < LANES; j++)
          if (j < k)
            for (int d = 0; d < 2; d++)
              if (lane_v[j] && dst_use[j][d] && dst_arch[j][d] == dst_arch[k][s])
                o = new_tag[j][d];
        if (s == int'(rn_pkg::SLOT_B) && dst_use[k][0] && dst_arch[k][0] == dst_arch[k][1])
          o = new_tag[k][0];
        pold[k][s] = o;
      end
    end
  end
endmodule

// File: rtl/reg_rename4.sv
module reg_rename4 #(
  parameter int LANES     = rn_pkg::RN_LANES,
  parameter int ARCH_REGS = rn_pkg::RN_ARCH_REGS,
  parameter int PHYS_REGS = rn_pkg::RN_PHYS_REGS,
  localparam int AREG_W   = $clog2(ARCH_REGS),
  localparam int PTAG_W   = $clog2(PHYS_REGS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          in_valid,
  input  logic [LANES-1:0]              in_lane_v,
  input  logic [LANES-1:0][1:0]         in_src_use,
  input  logic [LANES-1:0][1:0][AREG_W-1:0] in_src,
  input  logic [LANES-1:0][1:0]         in_dst_use,
  input  logic [LANES-1:0][1:0][AREG_W-1:0] in_dst,
  output logic                          in_ready,
  output logic                          out_valid,
  output logic [LANES-1:0]              out_lane_v,
  output logic [LANES-1:0][1:0][PTAG_W-1:0] out_psrc,
  output logic [LANES-1:0][1:0][PTAG_W-1:0] out_pdst,
  output logic [LANES-1:0][1:0][PTAG_W-1:0] out_pold,
  input  logic [LANES-1:0]              fr_v,
  input  logic [LANES-1:0][PTAG_W-1:0]  fr_tag,
  input  logic [LANES-1:0]              cm_v,
  input  logic [LANES-1:0][AREG_W-1:0]  cm_arch,
  input  logic [LANES-1:0][PTAG_W-1:0]  cm_tag
);
  localparam int SLOTS    = 2 * LANES;
  localparam int CNT_W    = $clog2(SLOTS + 1);
  localparam int SEL_W    = $clog2(SLOTS);
  localparam int FL_PTR_W = $clog2(PHYS_REGS - ARCH_REGS) + 1;

  logic [LANES-1:0]                  lv;
  logic                              go;
  logic [CNT_W-1:0]                  need;
  logic [CNT_W-1:0]                  commit_num;
  logic [LANES-1:0][1:0][PTAG_W-1:0] new_tag;
  logic [SLOTS-1:0][PTAG_W-1:0]      fl_rd_tag;
  logic [FL_PTR_W-1:0]               fl_avail;
  logic [FL_PTR_W-1:0]               fl_head;
  logic [2*SLOTS-1:0][AREG_W-1:0]    map_rd_arch;
  logic [2*SLOTS-1:0][PTAG_W-1:0]    map_rd_tag;
  logic [SLOTS-1:0]                  wr_v;
  logic [SLOTS-1:0][AREG_W-1:0]      wr_arch;
  logic [SLOTS-1:0][PTAG_W-1:0]      wr_tag;
  logic [LANES-1:0][1:0][PTAG_W-1:0] map_src;
  logic [LANES-1:0][1:0][PTAG_W-1:0] map_old;

  assign lv = in_lane_v & {LANES{in_valid}};

  // Tag offsets: lane order, slot 0 before slot 1, only used slots count.
  always_comb begin
    logic [CNT_W-1:0] acc;
    acc     = '0;
    new_tag = '0;
    for (int k = 0; k < LANES; k++)
      for (int d = 0; d < 2; d++)
        if (lv[k] && in_dst_use[k][d]) begin
          new_tag[k][d] = fl_rd_tag[acc[SEL_W-1:0]];
          acc = acc + CNT_W'(1);
        end
    need = acc;
  end

  always_comb begin
    commit_num = '0;
    for (int l = 0; l < LANES; l++)
      if (cm_v[l]) commit_num = commit_num + CNT_W'(1);
  end

  assign in_ready   = !flush && (32'(fl_avail) >= 32'(need));
  assign go         = in_valid && in_ready;
  assign out_valid  = go;
  assign out_lane_v = lv & {LANES{go}};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    for (genvar s = 0; s < 2; s++) begin : g_slot
      assign map_rd_arch[2*k+s]       = in_src[k][s];
      assign map_rd_arch[SLOTS+2*k+s] = in_dst[k][s];
      assign map_src[k][s]            = map_rd_tag[2*k+s];
      assign map_old[k][s]            = map_rd_tag[SLOTS+2*k+s];
      assign wr_v[2*k+s]              = go && lv[k] && in_dst_use[k][s];
      assign wr_arch[2*k+s]           = in_dst[k][s];
      assign wr_tag[2*k+s]            = new_tag[k][s];
      assign out_pdst[k][s]           = (go && lv[k] && in_dst_use[k][s]) ? new_tag[k][s] : '0;
    end
  end

  rn_freelist #(.LANES(LANES), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_fl (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_en(go), .alloc_num(need), .commit_num(commit_num),
    .free_v(fr_v), .free_tag(fr_tag),
    .rd_tag(fl_rd_tag), .avail(fl_avail), .head_o(fl_head)
  );

  rn_maptable #(.LANES(LANES), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rd_arch(map_rd_arch), .rd_tag(map_rd_tag),
    .wr_v(wr_v), .wr_arch(wr_arch), .wr_tag(wr_tag),
    .cm_v(cm_v), .cm_arch(cm_arch), .cm_tag(cm_tag)
  );

  rn_bypass #(.LANES(LANES), .AREG_W(AREG_W), .PTAG_W(PTAG_W)) u_byp (
    .lane_v(lv), .src_arch(in_src), .dst_use(in_dst_use), .dst_arch(in_dst),
    .map_src(map_src), .map_old(map_old), .new_tag(new_tag),
    .psrc(out_psrc), .pold(out_pold)
  );
endmodule

// File: rtl/rn_check.sv
module rn_check #(
  parameter int LANES     = 4,
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  localparam int PTAG_W   = $clog2(PHYS_REGS),
  localparam int DEPTH    = PHYS_REGS - ARCH_REGS,
  localparam int FL_PTR_W = $clog2(DEPTH) + 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          flush,
  input logic                          out_valid,
  input logic [LANES-1:0]              in_lane_v,
  input logic [LANES-1:0]              out_lane_v,
  input logic [LANES-1:0][1:0]         in_dst_use,
  input logic [LANES-1:0][1:0][PTAG_W-1:0] out_pdst,
  input logic [FL_PTR_W-1:0]           fl_avail,
  input logic [FL_PTR_W-1:0]           fl_head
);
  assert_fl_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fl_avail) <= DEPTH);

  assert_stall_holds_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !flush) |=> (fl_head == $past(fl_head)));

  assert_flush_no_rename_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !out_valid);

  assert_lane_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_lane_v & ~in_lane_v) == '0);

  // R4: no duplicate tag among the used destinations of one accepted group.
  always @(posedge clk) begin
    if (rst_n && out_valid) begin
      for (int a = 0; a < 2*LANES; a++)
        for (int b = 0; b < 2*LANES; b++)
          if (a < b && out_lane_v[a/2] && in_dst_use[a/2][a%2]
              && out_lane_v[b/2] && in_dst_use[b/2][b%2])
            assert_unique_tags_R4: assert (out_pdst[a/2][a%2] != out_pdst[b/2][b%2]);
    end
  end
endmodule

bind reg_rename4 rn_check #(.LANES(LANES), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_rn_check (
  .clk(clk), .rst_n(rst_n), .flush(flush), .out_valid(out_valid),
  .in_lane_v(in_lane_v), .out_lane_v(out_lane_v), .in_dst_use(in_dst_use),
  .out_pdst(out_pdst), .fl_avail(fl_avail), .fl_head(fl_head)
);

// File: tb/reg_rename4_bench.sv
`timescale 1ns/1ps
module reg_rename4_bench;
  logic clk, rst_n, flush, in_valid, in_ready, out_valid;
  logic [3:0]            in_lane_v, out_lane_v, fr_v, cm_v;
  logic [3:0][1:0]       in_src_use, in_dst_use;
  logic [3:0][1:0][4:0]  in_src, in_dst;
  logic [3:0][1:0][5:0]  out_psrc, out_pdst, out_pold;
  logic [3:0][5:0]       fr_tag, cm_tag;
  logic [3:0][4:0]       cm_arch;

  reg_rename4 u_reg_rename4 (.*);

  typedef struct packed {
    bit rdy; bit [3:0] lv; bit [3:0][1:0] su; bit [3:0][1:0] du;
    bit [3:0][1:0][5:0] ps; bit [3:0][1:0][5:0] pd; bit [3:0][1:0][5:0] po;
  } exp_t;

  exp_t  eq[$];
  string rq[$];
  int map_m[32], cmap_m[32];
  int fq[$], alog[$], alog_arch[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int cm_seq = 0;

  logic [3:0]           st_lv;
  logic [3:0][1:0]      st_su, st_du;
  logic [3:0][1:0][4:0] st_src, st_dst;

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic zero_ports();
    in_valid = 0; in_lane_v = '0; in_src_use = '0; in_src = '0; in_dst_use = '0; in_dst = '0;
    flush = 0; fr_v = '0; fr_tag = '0; cm_v = '0; cm_arch = '0; cm_tag = '0;
  endtask

  task automatic lane(input int k, input int s0, input int s1, input int d0, input int d1);
    st_lv[k] = 1;
    st_su[k][0] = (s0 >= 0); st_src[k][0] = (s0 >= 0) ? 5'(s0) : 5'd0;
    st_su[k][1] = (s1 >= 0); st_src[k][1] = (s1 >= 0) ? 5'(s1) : 5'd0;
    st_du[k][0] = (d0 >= 0); st_dst[k][0] = (d0 >= 0) ? 5'(d0) : 5'd0;
    st_du[k][1] = (d1 >= 0); st_dst[k][1] = (d1 >= 0) ? 5'(d1) : 5'd0;
  endtask

  // Driver: presents one group and pushes the expected renamed result.
  task automatic issue(input string req);
    exp_t e;
    int need, w[32], t;
    @(negedge clk);
    zero_ports();
    in_valid = 1; in_lane_v = st_lv; in_src_use = st_su; in_src = st_src;
    in_dst_use = st_du; in_dst = st_dst;
    e = '0; e.lv = st_lv; e.su = st_su; e.du = st_du;
    need = 0;
    for (int k = 0; k < 4; k++) for (int d = 0; d < 2; d++) if (st_lv[k] && st_du[k][d]) need++;
    e.rdy = (fq.size() >= need);
    if (e.rdy) begin
      w = map_m;
      for (int k = 0; k < 4; k++) begin
        if (!st_lv[k]) continue;
        for (int s = 0; s < 2; s++) e.ps[k][s] = 6'(w[st_src[k][s]]);
        for (int d = 0; d < 2; d++) if (st_du[k][d]) begin
          e.po[k][d] = 6'(w[st_dst[k][d]]);
          t = fq.pop_front();
          alog.push_back(t); alog_arch.push_back(int'(st_dst[k][d]));
          e.pd[k][d] = 6'(t);
          w[st_dst[k][d]] = t;
        end
      end
      map_m = w;
    end
    eq.push_back(e); rq.push_back(req);
    st_lv = '0; st_su = '0; st_du = '0; st_src = '0; st_dst = '0;
  endtask

  task automatic free_tags(input int t0, input int t1, input int t2, input int t3, input bit [3:0] v);
    int tl[4];
    tl = '{t0, t1, t2, t3};
    @(negedge clk);
    zero_ports();
    for (int l = 0; l < 4; l++) if (v[l]) begin
      fr_v[l] = 1; fr_tag[l] = 6'(tl[l]); fq.push_back(tl[l]);
    end
  endtask

  // Commits the oldest n allocations to registers r20..r27; optional flush in the same cycle.
  task automatic commit_n(input int n, input bit do_flush);
    int a;
    @(negedge clk);
    zero_ports();
    for (int l = 0; l < n; l++) begin
      void'(alog_arch.pop_front());
      a = 20 + (cm_seq % 8); cm_seq++;
      cm_v[l] = 1; cm_arch[l] = 5'(a); cm_tag[l] = 6'(alog[0]);
      cmap_m[a] = alog.pop_front();
    end
    if (do_flush) begin
      flush = 1;
      map_m = cmap_m;
      fq = {alog, fq};
      alog.delete(); alog_arch.delete();
      #1;
      chk(in_ready == 1'b0, "R10", "in_ready during flush", in_ready, 0);
      chk(out_valid == 1'b0, "R10", "out_valid during flush", out_valid, 0);
    end
  endtask

  // Monitor / scoreboard.
  initial begin : mon
    exp_t e;
    string r;
    forever begin
      @(negedge clk); #1;
      if (eq.size() > 0) begin
        e = eq.pop_front(); r = rq.pop_front();
        chk(in_ready == e.rdy, "R7", "in_ready", in_ready, e.rdy);
        chk(out_valid == e.rdy, r, "out_valid", out_valid, e.rdy);
        chk(out_lane_v == (e.rdy ? e.lv : 4'b0), "R11", "out_lane_v", out_lane_v, e.rdy ? e.lv : 4'b0);
        if (e.rdy) for (int k = 0; k < 4; k++) for (int s = 0; s < 2; s++) begin
          if (e.lv[k] && e.su[k][s])
            chk(out_psrc[k][s] == e.ps[k][s], r, $sformatf("lane%0d src%0d", k, s), out_psrc[k][s], e.ps[k][s]);
          if (e.lv[k] && e.du[k][s]) begin
            chk(out_pdst[k][s] == e.pd[k][s], r, $sformatf("lane%0d new tag%0d", k, s), out_pdst[k][s], e.pd[k][s]);
            chk(out_pold[k][s] == e.po[k][s], r, $sformatf("lane%0d old tag%0d", k, s), out_pold[k][s], e.po[k][s]);
          end
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    st_lv = '0; st_su = '0; st_du = '0; st_src = '0; st_dst = '0;
    zero_ports();
    rst_n = 0;
    for (int i = 0; i < 32; i++) begin map_m[i] = i; cmap_m[i] = i; fq.push_back(32 + i); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    // R1/R2: identity mapping, no writers.
    for (int k = 0; k < 4; k++) lane(k, 2*k, 2*k+1, -1, -1);
    issue("R1");
    // R4: allocation order with sparse destinations.
    lane(0, 5, -1, 1, -1); lane(1, 1, 6, 2, 3); lane(2, 3, 2, -1, -1); lane(3, -1, 4, -1, 4);
    issue("R4");
    // R3/R5: load-with-update chain, repeated.
    for (int it = 0; it < 3; it++) begin
      lane(0, 3, -1, 3, 9); lane(1, 9, -1, 9, -1); lane(2, 9, 3, -1, -1); lane(3, 10, -1, 10, -1);
      issue("R3");
    end
    // R5/R6: every slot writes r7.
    for (int k = 0; k < 4; k++) lane(k, 7, -1, 7, 7);
    issue("R5");
    lane(0, 7, 9, -1, -1); lane(1, 3, 10, -1, -1);
    issue("R6");
    // R11: lanes 1 and 3 masked.
    for (int k = 0; k < 4; k++) lane(k, 12, -1, 12 + k, -1);
    st_lv[1] = 0; st_lv[3] = 0;
    issue("R11");
    for (int k = 0; k < 4; k++) lane(k, 12 + k, -1, -1, -1);
    issue("R11");
    // R7: drain with full groups, then stall, then confirm the map is untouched.
    while (fq.size() >= 8) begin
      for (int k = 0; k < 4; k++) lane(k, 11 + 2*k, -1, 11 + 2*k, 12 + 2*k);
      issue("R7");
    end
    for (int k = 0; k < 4; k++) lane(k, 11, -1, 19 + k, 27 - k);
    issue("R7");
    for (int k = 0; k < 4; k++) lane(k, 11 + 2*k, 12 + 2*k, -1, -1);
    issue("R7");
    // R9 then R8: commit oldest allocations, return eight tags, reuse them.
    commit_n(4, 0);
    commit_n(4, 0);
    free_tags(0, 1, 2, 3, 4'b1111);
    free_tags(4, 5, 6, 7, 4'b1111);
    for (int k = 0; k < 4; k++) lane(k, 13, -1, 1 + k, 5 + k);
    issue("R8");
    // R10: more commits, speculative group, flush with commits in the same cycle.
    commit_n(3, 0);
    for (int k = 0; k < 4; k++) lane(k, 9, -1, 9, 3);
    issue("R9");
    commit_n(2, 1);
    for (int k = 0; k < 4; k++) lane(k, 20 + 2*k, 21 + 2*k, 9 + k, 3);
    issue("R10");
    @(negedge clk); zero_ports();
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule